// File: doc/BRIEF.md
# Privilege-Gated Instruction Legality Checker

This decode-stage unit decides whether an instruction may execute at the hart's current privilege level. Each decoded instruction arrives as a vector of decode flags. Three of these flags say which mode the instruction needs: supervisor, hypervisor or machine. The unit holds a registered check pair, a mask and a value. An instruction is illegal when any flag selected by the mask differs from the matching bit of the value. When the instruction is illegal, the unit replaces the incoming exception cause with the illegal-instruction code. Otherwise the cause from fetch passes through unchanged.

The check pair has two parts. A fixed base part comes from parameters. A privilege part is rebuilt whenever a privilege-change strobe arrives. Bits for modes above the new level join the mask with a value of zero, so any instruction that sets one of them becomes illegal. For trap-return instructions the unit also decodes which level the return targets. It passes that tag down the pipeline.

Top module: `priv_legal_chk`

## Requirements
- R1: After reset the check pair is in the machine-level configuration. An instruction with any mix of privilege bits (S at bit 0, H at bit 1, M at bit 2) is legal if its base fields match.
- R2: At user level (encoding 0), an instruction with any of the three privilege bits set is illegal.
- R3: At supervisor level (encoding 1), the S bit alone is legal. The H or M bit is illegal.
- R4: At hypervisor level (encoding 2), the S and H bits are legal. The M bit is illegal.
- R5: At machine level (encoding 3), every combination of privilege bits is legal.
- R6: A mismatch on the base fields makes the instruction illegal at every level. With the defaults, bit 4 must be 1 and bit 5 must be 0.
- R7: An illegal instruction yields cause_o equal to the illegal code (default 2). A legal instruction passes fetch_cause_i through unchanged.
- R8: A new level takes effect in the cycle after the strobe. An instruction checked in the strobe cycle itself uses the old pair.
- R9: priv_lvl_i has no effect while priv_upd_i is low.
- R10: For a trap return (flag bit 3), xret_lvl_o decodes the privilege bits with priority M (3), then H (2), then S (1), then none (0).
- R11: xret_lvl_o is 0 for any instruction that is not a trap return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_upd_i | input | 1 | Privilege-change strobe |
| priv_lvl_i | input | 2 | New privilege level (U=0, S=1, H=2, M=3) |
| inst_flags_i | input | FLAG_W | Decode flags of the instruction in decode |
| fetch_cause_i | input | CAUSE_W | Exception cause arriving from fetch |
| cause_o | output | CAUSE_W | Resulting exception cause |
| xret_lvl_o | output | 2 | Trap-return target level tag |

## Verification
A wrong privilege part in the check pair shows up at cause_o in the first cycle after the faulty update. An instruction that sets a bit just above or just below the new level exposes it at once. The bench therefore checks each level with both boundary bits. An update that lands a cycle early or late shows at the strobe-cycle sample or at the sample one cycle later. A wrong priority in the return decode shows only when several privilege bits are set together, so those combinations are driven on purpose.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;
  typedef enum logic [1:0] {
    PL_USER  = 2'd0,
    PL_SUPER = 2'd1,
    PL_HYPER = 2'd2,
    PL_MACH  = 2'd3
  } priv_lvl_e;
endpackage

// File: rtl/priv_mask_reg.sv
module priv_mask_reg
  import priv_gate_pkg::*;
#(
  parameter int unsigned FLAG_W    = 12,
  parameter int unsigned BIT_S     = 0,
  parameter int unsigned BIT_H     = 1,
  parameter int unsigned BIT_M     = 2,
  parameter logic [FLAG_W-1:0] BASE_MASK = '0,
  parameter logic [FLAG_W-1:0] BASE_VAL  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  priv_lvl_e         lvl_i,
  output logic [FLAG_W-1:0] mask_o,
  output logic [FLAG_W-1:0] val_o
);
  localparam logic [FLAG_W-1:0] PRIV_MSK =
    (FLAG_W'(1) << BIT_S) | (FLAG_W'(1) << BIT_H) | (FLAG_W'(1) << BIT_M);
  localparam logic [FLAG_W-1:0] MASK_BASE = BASE_MASK & ~PRIV_MSK;
  localparam logic [FLAG_W-1:0] VAL_BASE  = BASE_VAL & ~PRIV_MSK;

  logic [FLAG_W-1:0] mask_q, mask_d;
  logic [FLAG_W-1:0] val_q, val_d;
  logic [FLAG_W-1:0] allowed;

  always_comb begin
    allowed = '0;
    if (lvl_i >= PL_SUPER) allowed[BIT_S] = 1'b1;
    if (lvl_i >= PL_HYPER) allowed[BIT_H] = 1'b1;
    if (lvl_i >= PL_MACH)  allowed[BIT_M] = 1'b1;
    mask_d = mask_q;
    val_d  = val_q;
    if (upd_i) begin
      mask_d = MASK_BASE | (PRIV_MSK & ~allowed);
      val_d  = VAL_BASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_BASE;
      val_q  <= VAL_BASE;
    end else begin
      mask_q <= mask_d;
      val_q  <= val_d;
    end
  end

  assign mask_o = mask_q;
  assign val_o  = val_q;

  p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_i) |-> ($stable(mask_q) && $stable(val_q)));
  p_user_all_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_i) && $past(lvl_i) == PL_USER) |-> ((mask_q & PRIV_MSK) == PRIV_MSK));
  p_mach_all_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_i) && $past(lvl_i) == PL_MACH) |-> ((mask_q & PRIV_MSK) == '0));
endmodule

// File: rtl/priv_legal_cmp.sv
module priv_legal_cmp #(
  parameter int unsigned FLAG_W    = 12,
  parameter int unsigned CAUSE_W   = 4,
  parameter logic [CAUSE_W-1:0] CAUSE_ILL = 4'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic [FLAG_W-1:0]  mask_i,
  input  logic [FLAG_W-1:0]  val_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic illegal;

  always_comb begin
    illegal = |((flags_i ^ val_i) & mask_i);
    cause_o = illegal ? CAUSE_ILL : cause_i;
  end

  p_pass_when_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((flags_i ^ val_i) & mask_i) == '0) |-> (cause_o == cause_i));
  p_cause_on_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((flags_i ^ val_i) & mask_i) != '0) |-> (cause_o == CAUSE_ILL));
endmodule

// File: rtl/priv_xret_dec.sv
module priv_xret_dec
  import priv_gate_pkg::*;
#(
  parameter int unsigned FLAG_W   = 12,
  parameter int unsigned BIT_S    = 0,
  parameter int unsigned BIT_H    = 1,
  parameter int unsigned BIT_M    = 2,
  parameter int unsigned BIT_XRET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flags_i,
  output priv_lvl_e         lvl_o
);
  always_comb begin
    lvl_o = PL_USER;
    if (flags_i[BIT_XRET]) begin
      if (flags_i[BIT_M])      lvl_o = PL_MACH;
      else if (flags_i[BIT_H]) lvl_o = PL_HYPER;
      else if (flags_i[BIT_S]) lvl_o = PL_SUPER;
      else                     lvl_o = PL_USER;
    end
  end

  p_tag_zero_non_xret_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_i[BIT_XRET] |-> (lvl_o == PL_USER));
  p_mach_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[BIT_XRET] && flags_i[BIT_M]) |-> (lvl_o == PL_MACH));
endmodule

// File: rtl/priv_legal_chk.sv
module priv_legal_chk
  import priv_gate_pkg::*;
#(
  parameter int unsigned FLAG_W    = 12,
  parameter int unsigned BIT_S     = 0,
  parameter int unsigned BIT_H     = 1,
  parameter int unsigned BIT_M     = 2,
  parameter int unsigned BIT_XRET  = 3,
  parameter int unsigned CAUSE_W   = 4,
  parameter logic [CAUSE_W-1:0] CAUSE_ILL = 4'd2,
  parameter logic [FLAG_W-1:0]  BASE_MASK = 12'h037,
  parameter logic [FLAG_W-1:0]  BASE_VAL  = 12'h015
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               priv_upd_i,
  input  logic [1:0]         priv_lvl_i,
  input  logic [FLAG_W-1:0]  inst_flags_i,
  input  logic [CAUSE_W-1:0] fetch_cause_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [1:0]         xret_lvl_o
);
  logic [FLAG_W-1:0] chk_mask, chk_val;
  priv_lvl_e         xret_lvl;

  priv_mask_reg #(
    .FLAG_W(FLAG_W), .BIT_S(BIT_S), .BIT_H(BIT_H), .BIT_M(BIT_M),
    .BASE_MASK(BASE_MASK), .BASE_VAL(BASE_VAL)
  ) u_mask (
    .clk(clk), .rst_n(rst_n), .upd_i(priv_upd_i),
    .lvl_i(priv_lvl_e'(priv_lvl_i)),
    .mask_o(chk_mask), .val_o(chk_val)
  );

  priv_legal_cmp #(
    .FLAG_W(FLAG_W), .CAUSE_W(CAUSE_W), .CAUSE_ILL(CAUSE_ILL)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .flags_i(inst_flags_i),
    .mask_i(chk_mask), .val_i(chk_val),
    .cause_i(fetch_cause_i), .cause_o(cause_o)
  );

  priv_xret_dec #(
    .FLAG_W(FLAG_W), .BIT_S(BIT_S), .BIT_H(BIT_H), .BIT_M(BIT_M), .BIT_XRET(BIT_XRET)
  ) u_xret (
    .clk(clk), .rst_n(rst_n), .flags_i(inst_flags_i), .lvl_o(xret_lvl)
  );

  assign xret_lvl_o = xret_lvl;
endmodule

// File: tb/priv_legal_chk_tb.sv
module priv_legal_chk_tb_top;
  localparam logic [11:0] BMASK = 12'h037;
  localparam logic [11:0] BVAL  = 12'h015;
  localparam logic [11:0] PRIVB = 12'h007;
  localparam logic [3:0]  ILL   = 4'd2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        priv_upd_i;
  logic [1:0]  priv_lvl_i;
  logic [11:0] inst_flags_i;
  logic [3:0]  fetch_cause_i;
  logic [3:0]  cause_o;
  logic [1:0]  xret_lvl_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] cur_lvl;

  always #2 clk = ~clk;

  priv_legal_chk dut_i (
    .clk(clk), .rst_n(rst_n), .priv_upd_i(priv_upd_i), .priv_lvl_i(priv_lvl_i),
    .inst_flags_i(inst_flags_i), .fetch_cause_i(fetch_cause_i),
    .cause_o(cause_o), .xret_lvl_o(xret_lvl_o)
  );

  function automatic logic [3:0] model_cause(logic [1:0] lvl, logic [11:0] f, logic [3:0] fc);
    logic [11:0] m, v, dis;
    dis = (lvl == 2'd0) ? 12'h007 : (lvl == 2'd1) ? 12'h006 : (lvl == 2'd2) ? 12'h004 : 12'h000;
    m = (BMASK & ~PRIVB) | dis;
    v = BVAL & ~PRIVB;
    return (((f ^ v) & m) != 0) ? ILL : fc;
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_level(logic [1:0] l);
    @(negedge clk);
    priv_upd_i = 1'b1; priv_lvl_i = l;
    @(negedge clk);
    priv_upd_i = 1'b0;
    cur_lvl = l;
  endtask

  task automatic probe(string req, logic [11:0] f, logic [3:0] fc);
    inst_flags_i = f; fetch_cause_i = fc;
    #1;
    check(req, cause_o, model_cause(cur_lvl, f, fc));
  endtask

  task automatic t_reset_r1();
    for (int p = 0; p < 8; p++) probe("R1", 12'h010 | 12'(p), 4'd0);
  endtask

  task automatic t_levels();
    set_level(2'd0);
    probe("R2", 12'h011, 4'd0); probe("R2", 12'h012, 4'd0);
    probe("R2", 12'h014, 4'd0); probe("R2", 12'h010, 4'd5);
    set_level(2'd1);
    probe("R3", 12'h011, 4'd0); probe("R3", 12'h012, 4'd0); probe("R3", 12'h014, 4'd0);
    set_level(2'd2);
    probe("R4", 12'h013, 4'd0); probe("R4", 12'h014, 4'd0); probe("R4", 12'h016, 4'd0);
    set_level(2'd3);
    probe("R5", 12'h017, 4'd0); probe("R5", 12'h01c, 4'd0);
  endtask

  task automatic t_base_r6();
    for (int l = 0; l < 4; l++) begin
      set_level(2'(l));
      probe("R6", 12'h000, 4'd0);
      probe("R6", 12'h030, 4'd0);
      probe("R6", 12'hfd0, 4'd0);
    end
  endtask

  task automatic t_cause_r7();
    set_level(2'd3);
    inst_flags_i = 12'h010; fetch_cause_i = 4'd7; #1;
    check("R7", cause_o, 4'd7);
    inst_flags_i = 12'h000; #1;
    check("R7", cause_o, ILL);
  endtask

  task automatic t_timing_r8();
    set_level(2'd3);
    @(negedge clk);
    priv_upd_i = 1'b1; priv_lvl_i = 2'd0;
    inst_flags_i = 12'h011; fetch_cause_i = 4'd0; #1;
    check("R8", cause_o, 4'd0);
    @(negedge clk);
    priv_upd_i = 1'b0; #1;
    check("R8", cause_o, ILL);
    cur_lvl = 2'd0;
  endtask

  task automatic t_ignore_r9();
    set_level(2'd1);
    priv_lvl_i = 2'd3;
    repeat (3) @(negedge clk);
    probe("R9", 12'h012, 4'd0);
    check("R9", cause_o, ILL);
  endtask

  task automatic t_xret();
    logic [1:0] e;
    for (int p = 0; p < 8; p++) begin
      inst_flags_i = 12'h018 | 12'(p); #1;
      e = p[2] ? 2'd3 : p[1] ? 2'd2 : p[0] ? 2'd1 : 2'd0;
      check("R10", {2'b00, xret_lvl_o}, {2'b00, e});
      inst_flags_i = 12'h010 | 12'(p); #1;
      check("R11", {2'b00, xret_lvl_o}, 4'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; priv_upd_i = 1'b0; priv_lvl_i = 2'd0;
    inst_flags_i = '0; fetch_cause_i = '0; cur_lvl = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_levels();
    t_base_r6();
    t_cause_r7();
    t_timing_r8();
    t_ignore_r9();
    t_xret();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule